// File: doc/BRIEF.md
# Strap majority reader

This block serves one read-only 32-bit strap register whose value is not kept in a flop. Three redundant copies of the strap word sit at the low end of a byte-wide fuse array. When the bus reads the strap offset, the block fetches the twelve bytes through a single byte-read port, one read at a time. It builds the three words and answers with a bit-by-bit two-of-three vote. A fault confined to one copy therefore never reaches software.

The bus side uses a request/response pair of ready/valid handshakes. The block accepts a new request only when it is idle. A request that arrives during a fetch waits on `req_ready_o` until the previous response has been taken. A full-width write to the strap offset is acknowledged without error and changes nothing. A partial-width access, or an access to any other offset, gets an error response and touches no array byte.

Top module: `strap_vote_reader`

## Requirements
- R1: After reset, `req_ready_o` is 1 and `rsp_valid_o` and `arr_rd_o` are 0.
- R2: A read with `req_be_i` = 4'hF at offset `STRAP_OFF` causes exactly 12 single-cycle `arr_rd_o` pulses, at array addresses `BASE_ADDR`+0 up to `BASE_ADDR`+11 in ascending order. Only one read is outstanding at a time. The next pulse comes in the cycle after the `arr_rvalid_i` that answers the previous one.
- R3: Copy k (k = 0, 1, 2) is built from array bytes 4k to 4k+3, little-endian: byte 4k supplies bits 7:0 and byte 4k+3 supplies bits 31:24.
- R4: Each bit of the read result is (a&b)|(a&c)|(b&c) of that bit in the three copies. Any corruption confined to a single copy leaves the result equal to the uncorrupted word.
- R5: `rsp_valid_o` rises two cycles after the cycle in which the twelfth `arr_rvalid_i` is seen. `rsp_valid_o`, `rsp_rdata_o` and `rsp_err_o` hold steady until `rsp_ready_i` is seen high.
- R6: `req_ready_o` is low from the cycle after a request is accepted until the cycle after its response handshake. A request held valid in that time is accepted afterwards, not dropped.
- R7: A write with `req_be_i` = 4'hF at offset `STRAP_OFF` issues no array read. It responds with `rsp_err_o` = 0 and `rsp_rdata_o` = 0, and a later strap read returns the same value as before the write.
- R8: Any access with `req_be_i` other than 4'hF, or with `req_addr_i` other than `STRAP_OFF`, issues no array read. It responds with `rsp_err_o` = 1 and `rsp_rdata_o` = 0.
- R9: A strap read responds with `rsp_err_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | BUS_AW | Register byte offset |
| req_be_i | input | WORD_W/8 | Byte enables; all ones for a full access |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response taken when high with valid |
| rsp_rdata_o | output | WORD_W | Read data (voted strap word, or 0) |
| rsp_err_o | output | 1 | Access rejected |
| arr_rd_o | output | 1 | Single-cycle byte read strobe to the fuse array |
| arr_addr_o | output | ARR_AW | Byte address of the read |
| arr_rdata_i | input | 8 | Returned byte |
| arr_rvalid_i | input | 1 | Returned byte valid |

## Verification
The assertions assume that the array port answers each read strobe with exactly one `arr_rvalid_i`, at least one cycle later. They also assume it never raises `arr_rvalid_i` unprompted. The outstanding-read and address-order properties rest on that. The bench's array responder therefore raises `arr_rvalid_i` only after a programmable delay of one cycle or more following each observed strobe. The bench changes array contents only while the block is idle with no response pending, so every fetch sees one consistent snapshot.

// File: rtl/strap_vote_pkg.sv
package strap_vote_pkg;

  localparam int unsigned STRAP_COPIES = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_VOTE,
    ST_RESP
  } seq_state_e;

  typedef enum logic [1:0] {
    KIND_FETCH,
    KIND_WR_OK,
    KIND_ERROR
  } req_kind_e;

endpackage

// File: rtl/strap_vote3.sv
module strap_vote3 #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] y_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y_o[i] = (a_i[i] & b_i[i]) | (a_i[i] & c_i[i]) | (b_i[i] & c_i[i]);
  end

endmodule

// File: rtl/strap_byte_gather.sv
module strap_byte_gather #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned COPIES = 3,
  localparam int unsigned BPW    = WORD_W / 8,
  localparam int unsigned NBYTES = COPIES * BPW,
  localparam int unsigned IDX_W  = $clog2(NBYTES)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [IDX_W-1:0]               idx_i,
  input  logic [7:0]                     byte_i,
  output logic [COPIES-1:0][WORD_W-1:0]  copies_o
);

  logic [7:0] bytes_q [NBYTES];

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bytes_q[g] <= '0;
      end else if (we_i && (idx_i == IDX_W'(g))) begin
        bytes_q[g] <= byte_i;
      end
    end
  end

  // little-endian: lowest address feeds the lowest bits of each copy
  for (genvar k = 0; k < COPIES; k++) begin : g_copy
    for (genvar j = 0; j < BPW; j++) begin : g_lane
      assign copies_o[k][8*j +: 8] = bytes_q[k*BPW + j];
    end
  end

endmodule

// File: rtl/strap_fetch_seq.sv
module strap_fetch_seq
  import strap_vote_pkg::*;
#(
  parameter int unsigned NBYTES    = 12,
  parameter int unsigned ARR_AW    = 10,
  parameter int unsigned BASE_ADDR = 0,
  localparam int unsigned IDX_W    = $clog2(NBYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  req_kind_e         req_kind_i,
  output logic              req_ready_o,
  input  logic              rsp_ready_i,
  output logic              rsp_valid_o,
  output logic              arr_rd_o,
  output logic [ARR_AW-1:0] arr_addr_o,
  input  logic              arr_rvalid_i,
  output logic              byte_we_o,
  output logic [IDX_W-1:0]  byte_idx_o,
  output logic              vote_o,
  output logic              direct_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBYTES - 1);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          if (req_kind_i == KIND_FETCH) begin
            state_d = ST_ISSUE;
            idx_d   = '0;
          end else begin
            state_d = ST_RESP;
          end
        end
      end
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT: begin
        if (arr_rvalid_i) begin
          if (idx_q == LAST_IDX) begin
            state_d = ST_VOTE;
          end else begin
            idx_d   = idx_q + 1'b1;
            state_d = ST_ISSUE;
          end
        end
      end
      ST_VOTE: state_d = ST_RESP;
      ST_RESP: if (rsp_ready_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign rsp_valid_o = (state_q == ST_RESP);
  assign arr_rd_o    = (state_q == ST_ISSUE);
  assign arr_addr_o  = ARR_AW'(BASE_ADDR) + ARR_AW'(idx_q);
  assign byte_we_o   = (state_q == ST_WAIT) && arr_rvalid_i;
  assign byte_idx_o  = idx_q;
  assign vote_o      = (state_q == ST_VOTE);
  assign direct_o    = (state_q == ST_IDLE) && req_valid_i && (req_kind_i != KIND_FETCH);

endmodule

// File: rtl/strap_vote_reader.sv
module strap_vote_reader
  import strap_vote_pkg::*;
#(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned BUS_AW    = 12,
  parameter int unsigned STRAP_OFF = 'h10,
  parameter int unsigned ARR_AW    = 10,
  parameter int unsigned BASE_ADDR = 0,
  localparam int unsigned BE_W     = WORD_W / 8,
  localparam int unsigned NBYTES   = STRAP_COPIES * BE_W,
  localparam int unsigned IDX_W    = $clog2(NBYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [BUS_AW-1:0] req_addr_i,
  input  logic [BE_W-1:0]   req_be_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [WORD_W-1:0] rsp_rdata_o,
  output logic              rsp_err_o,
  output logic              arr_rd_o,
  output logic [ARR_AW-1:0] arr_addr_o,
  input  logic [7:0]        arr_rdata_i,
  input  logic              arr_rvalid_i
);

  req_kind_e  kind;
  logic       hit, full;

  assign hit  = (req_addr_i == BUS_AW'(STRAP_OFF));
  assign full = &req_be_i;

  always_comb begin
    if (!hit || !full)    kind = KIND_ERROR;
    else if (req_write_i) kind = KIND_WR_OK;
    else                  kind = KIND_FETCH;
  end

  logic             byte_we, vote, direct;
  logic [IDX_W-1:0] byte_idx;

  strap_fetch_seq #(
    .NBYTES   (NBYTES),
    .ARR_AW   (ARR_AW),
    .BASE_ADDR(BASE_ADDR)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_kind_i  (kind),
    .req_ready_o (req_ready_o),
    .rsp_ready_i (rsp_ready_i),
    .rsp_valid_o (rsp_valid_o),
    .arr_rd_o    (arr_rd_o),
    .arr_addr_o  (arr_addr_o),
    .arr_rvalid_i(arr_rvalid_i),
    .byte_we_o   (byte_we),
    .byte_idx_o  (byte_idx),
    .vote_o      (vote),
    .direct_o    (direct)
  );

  logic [STRAP_COPIES-1:0][WORD_W-1:0] copies;

  strap_byte_gather #(
    .WORD_W(WORD_W),
    .COPIES(STRAP_COPIES)
  ) u_gather (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (byte_we),
    .idx_i   (byte_idx),
    .byte_i  (arr_rdata_i),
    .copies_o(copies)
  );

  logic [WORD_W-1:0] voted;

  strap_vote3 #(.W(WORD_W)) u_vote (
    .a_i(copies[0]),
    .b_i(copies[1]),
    .c_i(copies[2]),
    .y_o(voted)
  );

  logic [WORD_W-1:0] rdata_q;
  logic              err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else if (vote) begin
      rdata_q <= voted;
      err_q   <= 1'b0;
    end else if (direct) begin
      rdata_q <= '0;
      err_q   <= (kind == KIND_ERROR);
    end
  end

  assign rsp_rdata_o = rdata_q;
  assign rsp_err_o   = err_q;

endmodule

// File: rtl/strap_vote_reader_chk.sv
module strap_vote_reader_chk #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned ARR_AW    = 10,
  parameter int unsigned BASE_ADDR = 0,
  parameter int unsigned NBYTES    = 12,
  localparam int unsigned CW       = $clog2(NBYTES + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              rsp_ready_i,
  input logic [WORD_W-1:0] rsp_rdata_o,
  input logic              rsp_err_o,
  input logic              arr_rd_o,
  input logic [ARR_AW-1:0] arr_addr_o,
  input logic              arr_rvalid_i
);

  logic [1:0]        out_q;
  logic              seen_q;
  logic [ARR_AW-1:0] last_q;
  logic [CW-1:0]     nrd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      seen_q <= 1'b0;
      last_q <= '0;
      nrd_q  <= '0;
    end else begin
      if (arr_rd_o)          out_q <= out_q + 1'b1;
      else if (arr_rvalid_i) out_q <= out_q - 1'b1;
      if (rsp_valid_o && rsp_ready_i) begin
        seen_q <= 1'b0;
        nrd_q  <= '0;
      end else if (arr_rd_o) begin
        seen_q <= 1'b1;
        last_q <= arr_addr_o;
        nrd_q  <= nrd_q + 1'b1;
      end
    end
  end

  p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!rsp_valid_o && !arr_rd_o));

  p_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_ready_i) |=> req_ready_o);

  p_rsp_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=>
      (rsp_valid_o && $stable(rsp_rdata_o) && $stable(rsp_err_o)));

  p_rd_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_rd_o |=> !arr_rd_o);

  p_one_outstanding_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_rd_o |-> (out_q == 2'd0));

  p_first_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_rd_o && !seen_q) |-> (arr_addr_o == ARR_AW'(BASE_ADDR)));

  p_next_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_rd_o && seen_q) |-> (arr_addr_o == last_q + 1'b1));

  p_read_count_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rsp_valid_o) && seen_q) |-> (nrd_q == CW'(NBYTES)));

  p_err_nofetch_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_err_o) |-> (!seen_q && rsp_rdata_o == '0));

endmodule

bind strap_vote_reader strap_vote_reader_chk #(
  .WORD_W   (WORD_W),
  .ARR_AW   (ARR_AW),
  .BASE_ADDR(BASE_ADDR),
  .NBYTES   (NBYTES)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_ready_i (rsp_ready_i),
  .rsp_rdata_o (rsp_rdata_o),
  .rsp_err_o   (rsp_err_o),
  .arr_rd_o    (arr_rd_o),
  .arr_addr_o  (arr_addr_o),
  .arr_rvalid_i(arr_rvalid_i)
);

// File: tb/strap_vote_reader_bench.sv
module strap_vote_reader_bench;

  localparam int CLK_PERIOD = 10;
  localparam int OFF        = 'h10;
  localparam int NB         = 12;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic        req_write_i = 1'b0;
  logic [11:0] req_addr_i = '0;
  logic [3:0]  req_be_i = '0;
  logic        rsp_valid_o;
  logic        rsp_ready_i = 1'b1;
  logic [31:0] rsp_rdata_o;
  logic        rsp_err_o;
  logic        arr_rd_o;
  logic [9:0]  arr_addr_o;
  logic [7:0]  arr_rdata_i = '0;
  logic        arr_rvalid_i = 1'b0;

  strap_vote_reader u_strap_vote_reader (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_write_i(req_write_i), .req_addr_i(req_addr_i), .req_be_i(req_be_i),
    .rsp_valid_o(rsp_valid_o), .rsp_ready_i(rsp_ready_i),
    .rsp_rdata_o(rsp_rdata_o), .rsp_err_o(rsp_err_o),
    .arr_rd_o(arr_rd_o), .arr_addr_o(arr_addr_o),
    .arr_rdata_i(arr_rdata_i), .arr_rvalid_i(arr_rvalid_i)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_cmp = 0, n_bad = 0;
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // fuse array model
  logic [7:0] mem [NB];
  int rd_lat = 1;
  int rd_cnt = 0;
  int hs_cnt = 0;
  bit rsp_rand = 0;

  function automatic logic [31:0] copy_of(input int k);
    return {mem[4*k+3], mem[4*k+2], mem[4*k+1], mem[4*k]};
  endfunction

  function automatic logic [31:0] majority();
    logic [31:0] r = '0;
    for (int b = 0; b < 32; b++) begin
      int ones = 0;
      for (int k = 0; k < 3; k++) ones += int'(copy_of(k)[b]);
      r[b] = (ones >= 2);
    end
    return r;
  endfunction

  task automatic set_copy(input int k, input logic [31:0] w);
    for (int j = 0; j < 4; j++) mem[4*k+j] = w[8*j +: 8];
  endtask

  task automatic set_all(input logic [31:0] w);
    for (int k = 0; k < 3; k++) set_copy(k, w);
  endtask

  // responder: answers each strobe after rd_lat cycles
  initial begin
    int cnt = 0;
    int a = 0;
    forever begin
      @(posedge clk_i); #1;
      arr_rvalid_i = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          arr_rvalid_i = 1'b1;
          arr_rdata_i  = mem[a];
        end
      end
      if (arr_rd_o) begin
        cnt = rd_lat;
        a   = int'(arr_addr_o);
      end
    end
  end

  // response-ready driver
  initial begin
    forever begin
      @(posedge clk_i); #1;
      rsp_ready_i = rsp_rand ? ($urandom_range(0, 3) != 0) : 1'b1;
    end
  end

  // expected responses
  logic [31:0] q_data[$];
  bit          q_err[$];
  bit          q_rd[$];
  string       q_tag[$];
  logic [31:0] last_data = '0;

  // behavioural cycle model: 0 idle,1 strobe,2 awaiting byte,3 voting,4 responding
  int m_ph = 0, m_idx = 0;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph = 0; m_idx = 0;
    end else begin
      case (m_ph)
        0: if (req_valid_i) begin
             if (!req_write_i && req_be_i == 4'hF && req_addr_i == 12'(OFF)) begin
               m_ph = 1; m_idx = 0;
             end else m_ph = 4;
           end
        1: m_ph = 2;
        2: if (arr_rvalid_i) begin
             if (m_idx == NB-1) m_ph = 3;
             else begin m_idx++; m_ph = 1; end
           end
        3: m_ph = 4;
        default: if (rsp_ready_i) m_ph = 0;
      endcase
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      chk(req_ready_o == (m_ph == 0), "R6 req_ready", 32'(req_ready_o), 32'(m_ph == 0));
      chk(arr_rd_o == (m_ph == 1), "R2 arr_rd", 32'(arr_rd_o), 32'(m_ph == 1));
      if (m_ph == 1) chk(arr_addr_o == 10'(m_idx), "R2 arr_addr", 32'(arr_addr_o), 32'(m_idx));
      chk(rsp_valid_o == (m_ph == 4), "R5 rsp_valid", 32'(rsp_valid_o), 32'(m_ph == 4));
      if (arr_rd_o) rd_cnt++;
      if (rsp_valid_o) begin
        if (q_data.size() == 0) chk(1'b0, "R5 unexpected response", rsp_rdata_o, 32'h0);
        else begin
          chk(rsp_rdata_o == q_data[0], q_tag[0], rsp_rdata_o, q_data[0]);
          chk(rsp_err_o == q_err[0], q_rd[0] ? "R9 err" : q_tag[0], 32'(rsp_err_o), 32'(q_err[0]));
          if (rsp_ready_i) begin
            last_data = rsp_rdata_o;
            hs_cnt++;
            void'(q_data.pop_front()); void'(q_err.pop_front());
            void'(q_rd.pop_front());   void'(q_tag.pop_front());
          end
        end
      end
    end
  end

  task automatic send(input bit wr, input logic [11:0] addr, input logic [3:0] be, input string tag);
    @(posedge clk_i); #1;
    req_valid_i = 1'b1; req_write_i = wr; req_addr_i = addr; req_be_i = be;
    forever begin
      @(negedge clk_i);
      if (req_ready_o) break;
    end
    begin
      bit ok = (addr == 12'(OFF)) && (be == 4'hF);
      bit rd = ok && !wr;
      q_data.push_back(rd ? majority() : 32'h0);
      q_err.push_back(!ok);
      q_rd.push_back(rd);
      q_tag.push_back(tag);
    end
    @(posedge clk_i); #1;
    req_valid_i = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk_i); while (!(req_ready_o && q_data.size() == 0));
  endtask

  task automatic read_and_wait(input string tag);
    send(1'b0, 12'(OFF), 4'hF, tag);
    wait_idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_cmp++; n_bad++;
    $display("FAIL R5 watchdog act=hung exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int c0;
    logic [31:0] g;
    for (int i = 0; i < NB; i++) mem[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R1 ready", 32'(req_ready_o), 32'h1);
    chk(rsp_valid_o == 1'b0, "R1 rsp_valid", 32'(rsp_valid_o), 32'h0);
    chk(arr_rd_o == 1'b0, "R1 arr_rd", 32'(arr_rd_o), 32'h0);

    // plain read, equal copies
    set_all(32'hA5C3_0F96);
    c0 = rd_cnt;
    read_and_wait("R4 equal copies");
    chk(rd_cnt - c0 == NB, "R2 byte reads", 32'(rd_cnt - c0), 32'(NB));
    chk(last_data == 32'hA5C3_0F96, "R3 value", last_data, 32'hA5C3_0F96);

    // byte order, bytes 4k..4k+3 ascending
    for (int k = 0; k < 3; k++) begin
      mem[4*k] = 8'h78; mem[4*k+1] = 8'h56; mem[4*k+2] = 8'h34; mem[4*k+3] = 8'h12;
    end
    read_and_wait("R3 little-endian");
    chk(last_data == 32'h1234_5678, "R3 byte order", last_data, 32'h1234_5678);

    // single-copy corruption
    g = 32'h5EED_C0DE;
    for (int k = 0; k < 3; k++) begin
      set_all(g);
      set_copy(k, g ^ (32'h8000_0101 << k));
      read_and_wait("R4 one copy flipped");
      chk(last_data == g, "R4 flip copy", last_data, g);
    end
    set_all(g);
    set_copy(1, ~g);
    read_and_wait("R4 copy inverted");
    chk(last_data == g, "R4 inverted copy", last_data, g);
    set_copy(0, g ^ 32'h1); set_copy(1, g ^ 32'h20); set_copy(2, g ^ 32'h8000_0000);
    read_and_wait("R4 disjoint flips");
    chk(last_data == g, "R4 disjoint flips", last_data, g);

    // unrelated copies, slow array, random response back-pressure
    rd_lat = 3;
    rsp_rand = 1;
    for (int n = 0; n < 6; n++) begin
      for (int i = 0; i < NB; i++) mem[i] = 8'($urandom);
      read_and_wait("R4 random copies");
    end
    rd_lat = 2;

    // ignored write
    set_all(32'hCAFE_F00D);
    set_copy(2, 32'h0);
    g = majority();
    c0 = rd_cnt;
    send(1'b1, 12'(OFF), 4'hF, "R7 write ack");
    wait_idle();
    chk(rd_cnt == c0, "R7 no array read", 32'(rd_cnt - c0), 32'h0);
    read_and_wait("R7 read after write");
    chk(last_data == g, "R7 unchanged", last_data, g);

    // rejected accesses
    c0 = rd_cnt;
    send(1'b0, 12'(OFF), 4'h7, "R8 partial read");
    send(1'b1, 12'(OFF), 4'h3, "R8 partial write");
    send(1'b0, 12'(OFF + 4), 4'hF, "R8 wrong offset");
    wait_idle();
    chk(rd_cnt == c0, "R8 no array read", 32'(rd_cnt - c0), 32'h0);

    // requests held while busy
    c0 = hs_cnt;
    rd_lat = 1;
    send(1'b0, 12'(OFF), 4'hF, "R6 first read");
    send(1'b0, 12'h0, 4'hF, "R6 stalled error");
    send(1'b0, 12'(OFF), 4'hF, "R6 stalled read");
    wait_idle();
    chk(hs_cnt - c0 == 3, "R6 none dropped", 32'(hs_cnt - c0), 32'h3);

    rsp_rand = 0;
    repeat (4) @(negedge clk_i);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule